// File: doc/BRIEF.md
# Two-Level Prioritized Interrupt Controller

This block gathers fifteen interrupt request lines, numbered 1 to 15, and hands each of one or more processors a 4-bit interrupt number to service. A rising edge on a request line marks that line pending. Software can also force lines per processor, and can route a line to the force registers of all processors at once. Every processor has its own mask. A level register splits the lines into a high and a low priority group. Each processor's output always takes the high group first, and within the chosen group it reports the highest-numbered line.

Software reaches the registers over a plain 32-bit read/write bus with byte addresses inside a 256-byte window. Reads return data in the same cycle and writes take effect at the clock edge. When a processor takes an interrupt it pulses its acknowledge with the line number. That clears the line from the shared pending register and from that processor's force register.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset every register reads as zero and every processor's level output is 0.
- R2: Bit 0 of every line bitmask is always zero. A write to the level register (offset 0x00) keeps data bits 1..16 (data & 0x1FFFE). Writes to broadcast (0x14), clear (0x0C) and the processor-0 force alias (0x08) keep bits 1..15. A mask write (0x40 + 4n) stores the whole word with bit 0 cleared.
- R3: A 0-to-1 transition on request line k (k = 1..15) whose broadcast bit is 0 sets bit k of pending (read at 0x04). A line held high does not set the bit again after it has been cleared.
- R4: Each processor's 4-bit level output is the highest-numbered bit of its selected set, or 0 when that set is empty. The output is registered and follows a register write, request or acknowledge one clock later.
- R5: For processor n the active set is (pending OR force[n]) AND mask[n]. If any active bit has its level bit set to 1, only those bits are selected. Otherwise the active bits with level bit 0 are selected.
- R6: An acknowledge from processor n carrying number k clears bit k of pending and of force[n] only. The force registers of other processors are unchanged.
- R7: A write to force[n] at 0x80 + 4n yields (old OR (data & 0xFFFE)) AND NOT ((data >> 16) & 0xFFFE). A write to 0x08 replaces force[0] with data & 0xFFFE. Reads at 0x08 and 0x80 both return force[0].
- R8: A write to 0x0C clears the written bits from pending. Reads at 0x0C and 0x10 return 0. Writes to 0x04 and 0x10 have no effect.
- R9: A request rising on line k while broadcast bit k is 1 sets bit k in every processor's force register and leaves pending unchanged.
- R10: A write to slot 0xC0 + 4n stores data bits 3..0, and the slot reads them back zero-extended.
- R11: Offsets outside the map, and per-processor offsets for a processor index not present, read as 0 and ignore writes. Mask, force and slot registers are separate for each processor.
- R12: When a request rises on line k in the same cycle as a clear write covering bit k, pending bit k ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset in the window; bits 1..0 are ignored |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the cycle of a read |
| irqReq | input | 16 | Request lines; bit 0 is unused |
| ackValid | input | NUM_CPU | Acknowledge pulse, one per processor |
| ackNum | input | 4·NUM_CPU | Acknowledged line number, 4 bits per processor |
| cpuLevel | output | 4·NUM_CPU | Interrupt number presented to each processor |

## Verification
The assertions check four things on every cycle. Bit 0 never appears in pending, level or broadcast. A request beats a clear of the same pending bit. An acknowledge removes the line from pending unless the line rises again in that cycle. A processor with an empty active set shows level 0 one cycle later. The status and clear offsets are also checked to read as zero. Some behaviours can only be shown by the bench's scenarios: the high-over-low choice, the highest-number pick, the set-and-clear arithmetic of force writes, the broadcast redirect, per-processor isolation and register readback.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_LEVEL,
    RD_PEND,
    RD_FORCE,
    RD_BCAST,
    RD_MASK,
    RD_SLOT
  } rdKind_e;

  // Strobes from the bus decoder to the register datapath.
  typedef struct packed {
    logic       wrLevel;
    logic       wrAlias;
    logic       wrClear;
    logic       wrBcast;
    logic       wrMask;
    logic       wrForce;
    logic       wrSlot;
    logic [3:0] cpu;
    rdKind_e    rdKind;
  } busStrobe_t;

endpackage

// File: rtl/irq_bus_ctl.sv
module irq_bus_ctl
  import prio_irq_pkg::*;
#(
  parameter int NUM_CPU = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [7:0] busAddr,
  output busStrobe_t st
);

  logic [3:0] word;
  logic       cpuOk;
  logic       doWr;

  assign word  = busAddr[5:2];
  assign cpuOk = ({28'd0, word} < 32'(NUM_CPU));
  assign doWr  = busSel && busWr;

  always_comb begin
    st        = '0;
    st.cpu    = word;
    st.rdKind = RD_ZERO;
    unique case (busAddr[7:6])
      2'b00: begin
        unique case (word)
          4'd0: begin st.rdKind = RD_LEVEL; st.wrLevel = doWr; end
          4'd1: st.rdKind = RD_PEND;
          4'd2: begin st.rdKind = RD_FORCE; st.cpu = 4'd0; st.wrAlias = doWr; end
          4'd3: st.wrClear = doWr;
          4'd5: begin st.rdKind = RD_BCAST; st.wrBcast = doWr; end
          default: ;
        endcase
      end
      2'b01: if (cpuOk) begin st.rdKind = RD_MASK;  st.wrMask  = doWr; end
      2'b10: if (cpuOk) begin st.rdKind = RD_FORCE; st.wrForce = doWr; end
      default: if (cpuOk) begin st.rdKind = RD_SLOT; st.wrSlot = doWr; end
    endcase
  end

  // R11: at most one register takes a given write
  p_single_target_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.wrLevel, st.wrAlias, st.wrClear, st.wrBcast, st.wrMask, st.wrForce, st.wrSlot}));

endmodule

// File: rtl/irq_state_dp.sv
module irq_state_dp
  import prio_irq_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int LINES   = 16,
  parameter int LW      = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  busStrobe_t            st,
  input  logic [31:0]           busWdata,
  output logic [31:0]           rdMux,
  input  logic [LINES-1:0]      irqReq,
  input  logic [NUM_CPU-1:0]    ackValid,
  input  logic [NUM_CPU*LW-1:0] ackNum,
  output logic [NUM_CPU*LW-1:0] cpuLevel
);

  localparam int CW    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int SLOTS = 1 << CW;
  localparam logic [LINES-1:0] VALID = {{(LINES-1){1'b1}}, 1'b0};

  logic [LINES-1:0] reqPrev, pendReg, bcastReg, reqRise, ackAll, pendNext, wSet, wClr;
  logic [LINES:0]   levelReg;
  logic [31:0]      maskArr  [SLOTS];
  logic [LINES-1:0] forceArr [SLOTS];
  logic [3:0]       slotArr  [SLOTS];

  function automatic logic [LW-1:0] topBit(input logic [LINES-1:0] v);
    logic [LW-1:0] r;
    r = '0;
    for (int i = 0; i < LINES; i++) if (v[i]) r = LW'(i);
    return r;
  endfunction

  assign reqRise = irqReq & ~reqPrev & VALID;
  assign wSet    = busWdata[LINES-1:0] & VALID;
  assign wClr    = busWdata[2*LINES-1:LINES] & VALID;

  always_comb begin
    ackAll = '0;
    for (int n = 0; n < NUM_CPU; n++)
      if (ackValid[n]) ackAll[ackNum[n*LW +: LW]] = 1'b1;
  end

  // request wins over clear and acknowledge of the same bit
  assign pendNext = (pendReg & ~(st.wrClear ? wSet : '0) & ~ackAll) | (reqRise & ~bcastReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqPrev  <= '0;
      pendReg  <= '0;
      levelReg <= '0;
      bcastReg <= '0;
    end else begin
      reqPrev <= irqReq;
      pendReg <= pendNext;
      if (st.wrLevel) levelReg <= busWdata[LINES:0] & {1'b1, VALID};
      if (st.wrBcast) bcastReg <= wSet;
    end
  end

  for (genvar n = 0; n < SLOTS; n++) begin : g_cpu
    if (n < NUM_CPU) begin : g_on
      logic [31:0]      maskR;
      logic [LINES-1:0] forceR, forceNext, activeSet, hiSet;
      logic [3:0]       slotR;
      logic [LW-1:0]    lvlR, ackIdx;

      assign ackIdx    = ackNum[n*LW +: LW];
      assign activeSet = (pendReg | forceR) & maskR[LINES-1:0] & VALID;
      assign hiSet     = activeSet & levelReg[LINES-1:0];

      always_comb begin
        forceNext = forceR;
        if (st.wrAlias && (n == 0)) forceNext = wSet;
        if (st.wrForce && (st.cpu == 4'(n))) forceNext = (forceR | wSet) & ~wClr;
        if (ackValid[n]) forceNext[ackIdx] = 1'b0;
        forceNext = forceNext | (reqRise & bcastReg);
      end

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          maskR  <= '0;
          forceR <= '0;
          slotR  <= '0;
          lvlR   <= '0;
        end else begin
          forceR <= forceNext;
          if (st.wrMask && (st.cpu == 4'(n))) maskR <= busWdata & ~32'd1;
          if (st.wrSlot && (st.cpu == 4'(n))) slotR <= busWdata[3:0];
          lvlR <= topBit((hiSet != '0) ? hiSet : activeSet);
        end
      end

      assign maskArr[n]  = maskR;
      assign forceArr[n] = forceR;
      assign slotArr[n]  = slotR;
      assign cpuLevel[n*LW +: LW] = lvlR;

      // R6: acknowledge drops the line from pending unless it rises again now
      p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
        (ackValid[n] && !reqRise[ackIdx]) |=> !pendReg[$past(ackIdx)]);

      // R4: empty active set gives level 0 on the next cycle
      p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
        (activeSet == '0) |=> (lvlR == '0));
    end else begin : g_off
      assign maskArr[n]  = '0;
      assign forceArr[n] = '0;
      assign slotArr[n]  = '0;
    end
  end

  always_comb begin
    unique case (st.rdKind)
      RD_LEVEL: rdMux = 32'(levelReg);
      RD_PEND:  rdMux = 32'(pendReg);
      RD_FORCE: rdMux = 32'(forceArr[st.cpu[CW-1:0]]);
      RD_BCAST: rdMux = 32'(bcastReg);
      RD_MASK:  rdMux = maskArr[st.cpu[CW-1:0]];
      RD_SLOT:  rdMux = 32'(slotArr[st.cpu[CW-1:0]]);
      default:  rdMux = '0;
    endcase
  end

  // R2: reserved bit 0 never held
  p_bit0_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !pendReg[0] && !bcastReg[0] && !levelReg[0]);

  // R12: a rising request survives a same-cycle clear
  p_req_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    ((reqRise & ~bcastReg) != '0) |=>
      ((pendReg & $past(reqRise & ~bcastReg)) == $past(reqRise & ~bcastReg)));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int NUM_CPU = 2,
  parameter int LINES   = 16,
  parameter int LW      = $clog2(LINES)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [7:0]            busAddr,
  input  logic [31:0]           busWdata,
  output logic [31:0]           busRdata,
  input  logic [LINES-1:0]      irqReq,
  input  logic [NUM_CPU-1:0]    ackValid,
  input  logic [NUM_CPU*LW-1:0] ackNum,
  output logic [NUM_CPU*LW-1:0] cpuLevel
);

  busStrobe_t  st;
  logic [31:0] rdMux;

  irq_bus_ctl #(.NUM_CPU(NUM_CPU)) u_ctl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr),
    .busAddr(busAddr), .st(st)
  );

  irq_state_dp #(.NUM_CPU(NUM_CPU), .LINES(LINES), .LW(LW)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .busWdata(busWdata), .rdMux(rdMux),
    .irqReq(irqReq), .ackValid(ackValid), .ackNum(ackNum), .cpuLevel(cpuLevel)
  );

  assign busRdata = busSel ? rdMux : 32'd0;

  // R8: clear and status offsets read as zero
  p_status_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busWr && (busAddr[7:2] == 6'd3 || busAddr[7:2] == 6'd4)) |-> (busRdata == 32'd0));

endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;

  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0, busWr = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic [31:0]   busRdata;
  logic [15:0]   irqReq = '0;
  logic [NC-1:0] ackValid = '0;
  logic [NC*4-1:0] ackNum = '0;
  logic [NC*4-1:0] cpuLevel;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl #(.NUM_CPU(NC)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqReq(irqReq),
    .ackValid(ackValid), .ackNum(ackNum), .cpuLevel(cpuLevel)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic rdCheck(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1;
    check(tag, busRdata, exp);
    busSel = 1'b0;
  endtask

  task automatic setLine(input int k, input logic v);
    @(negedge clk);
    irqReq[k] = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ack(input int cpu, input logic [3:0] num);
    @(negedge clk);
    ackValid[cpu] = 1'b1; ackNum[cpu*4 +: 4] = num;
    @(posedge clk);
    @(negedge clk);
    ackValid = '0;
  endtask

  // wait for the registered level output to follow the state
  task automatic lvlCheck(input string tag, input int cpu, input logic [3:0] exp);
    @(posedge clk);
    @(negedge clk);
    check(tag, 32'(cpuLevel[cpu*4 +: 4]), 32'(exp));
  endtask

  task automatic t_reset;
    rdCheck("R1 level reg", 8'h00, 0);
    rdCheck("R1 pending", 8'h04, 0);
    rdCheck("R1 force0", 8'h08, 0);
    rdCheck("R1 broadcast", 8'h14, 0);
    rdCheck("R1 mask0", 8'h40, 0);
    check("R1 level outputs", 32'(cpuLevel), 0);
  endtask

  task automatic t_request;
    wr(8'h40, 32'hFFFF_FFFF);
    rdCheck("R2 mask bit0 stripped", 8'h40, 32'hFFFF_FFFE);
    setLine(5, 1'b1);
    rdCheck("R3 rise sets pending", 8'h04, 32'h20);
    lvlCheck("R4 cpu0 level 5", 0, 4'd5);
    check("R11 cpu1 masked", 32'(cpuLevel[7:4]), 0);
    setLine(9, 1'b1);
    lvlCheck("R4 highest wins", 0, 4'd9);
    wr(8'h0C, 32'h0000_0201);
    rdCheck("R8 clear bit 9", 8'h04, 32'h20);
    @(negedge clk);
    rdCheck("R3 held line no re-set", 8'h04, 32'h20);
    lvlCheck("R4 back to 5", 0, 4'd5);
    setLine(5, 1'b0);
    setLine(9, 1'b0);
  endtask

  task automatic t_priority;
    wr(8'h00, 32'hFFFF_FFFF);
    rdCheck("R2 level keeps 1..16", 8'h00, 32'h0001_FFFE);
    wr(8'h00, 32'h0000_0008);
    setLine(3, 1'b1);
    rdCheck("R3 pending 3 and 5", 8'h04, 32'h28);
    lvlCheck("R5 high group first", 0, 4'd3);
    wr(8'h00, 32'h0);
    lvlCheck("R5 low group used", 0, 4'd5);
    setLine(3, 1'b0);
  endtask

  task automatic t_ack;
    ack(0, 4'd5);
    rdCheck("R6 ack clears pending", 8'h04, 32'h08);
    lvlCheck("R4 after ack", 0, 4'd3);
    ack(0, 4'd3);
    rdCheck("R6 pending empty", 8'h04, 32'h0);
    lvlCheck("R4 empty gives 0", 0, 4'd0);
  endtask

  task automatic t_force;
    wr(8'h84, 32'h0000_0C00);
    rdCheck("R7 force1 set", 8'h84, 32'h0000_0C00);
    wr(8'h84, 32'h0400_0002);
    rdCheck("R7 force1 set and clear", 8'h84, 32'h0000_0802);
    wr(8'h08, 32'h0000_FFFF);
    rdCheck("R7 alias replace", 8'h08, 32'h0000_FFFE);
    rdCheck("R7 alias same as force0", 8'h80, 32'h0000_FFFE);
    lvlCheck("R4 forced 15", 0, 4'd15);
    check("R11 cpu1 still masked", 32'(cpuLevel[7:4]), 0);
    ack(1, 4'd11);
    rdCheck("R6 ack clears own force", 8'h84, 32'h0000_0002);
    rdCheck("R6 other force kept", 8'h80, 32'h0000_FFFE);
    wr(8'h08, 32'h0);
    wr(8'h84, 32'h0002_0000);
    rdCheck("R7 clear half", 8'h84, 32'h0);
  endtask

  task automatic t_broadcast;
    wr(8'h14, 32'h0000_0041);
    rdCheck("R2 broadcast bit0", 8'h14, 32'h40);
    setLine(6, 1'b1);
    rdCheck("R9 pending untouched", 8'h04, 32'h0);
    rdCheck("R9 force0 set", 8'h80, 32'h40);
    rdCheck("R9 force1 set", 8'h84, 32'h40);
    lvlCheck("R9 cpu0 sees 6", 0, 4'd6);
    wr(8'h08, 32'h0);
    wr(8'h84, 32'h0040_0000);
    wr(8'h14, 32'h0);
    setLine(6, 1'b0);
  endtask

  task automatic t_misc;
    wr(8'h04, 32'hFFFF);
    rdCheck("R8 pending write ignored", 8'h04, 32'h0);
    wr(8'h10, 32'hFFFF);
    rdCheck("R8 status reads 0", 8'h10, 32'h0);
    rdCheck("R8 clear reads 0", 8'h0C, 32'h0);
    wr(8'hC4, 32'hABCD);
    rdCheck("R10 slot keeps 4 bits", 8'hC4, 32'hD);
    rdCheck("R10 other slot", 8'hC0, 32'h0);
    wr(8'h20, 32'h1234);
    rdCheck("R11 unmapped reads 0", 8'h20, 32'h0);
    wr(8'h54, 32'hFFFF);
    rdCheck("R11 absent cpu mask", 8'h54, 32'h0);
    rdCheck("R11 no side effect", 8'h04, 32'h0);
  endtask

  task automatic t_collide;
    @(negedge clk);
    irqReq[12] = 1'b1;
    busSel = 1'b1; busWr = 1'b1; busAddr = 8'h0C; busWdata = 32'h1000;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    rdCheck("R12 request beats clear", 8'h04, 32'h1000);
    wr(8'h0C, 32'h1000);
    rdCheck("R8 later clear works", 8'h04, 32'h0);
    setLine(12, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_request();
    t_priority();
    t_ack();
    t_force();
    t_broadcast();
    t_misc();
    t_collide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule